// File: doc/BRIEF.md
# Channel Descriptor Pointer Queue with Two-Level Overflow Handling

This block sits in front of one processing channel. A host pushes 32-bit descriptor pointers into a small queue through a one-cycle write strobe. The channel takes pointers out, oldest first, through a pop request. A popped pointer appears on a registered output one cycle after the request. Around the queue sits the channel's error state: three sticky error flags, an error interrupt and a halt bit.

A write that finds the queue full is discarded. The first such write records a soft overflow, and the channel keeps running. A further full-queue write while the soft flag is still held records a hard overflow and halts the channel. A transfer error reported by the bus master also halts the channel. A halted channel stops popping but still takes host writes until the queue is full. It runs again only after a continue command or a channel reset command. A channel reset also empties the queue and clears every flag. Software clears individual flags by writing 1 to their bit positions.

Top module: `desc_fetch_chan`

## Requirements
- R1: After the synchronous active-high reset, err_flags is 000, err_irq is 0, halted is 0 and ptr_vld is 0.
- R2: A pop_req while the queue holds entries and the channel is not halted drives ptr_vld high in the next cycle, with ptr_data set to the oldest stored pointer. Pointers come out in write order. A pop_req on an empty queue leaves ptr_vld low.
- R3: A host write to a full queue, with no pop in the same cycle, discards the pointer and sets err_flags bit 0 (soft overflow) and err_irq in the next cycle. halted stays 0, and popping continues.
- R4: A host write to a full queue while err_flags bit 0 is already set also sets err_flags bit 1 (hard overflow) and sets halted. Bit 0 stays set.
- R5: A pulse on mst_err sets err_flags bit 2 (bus error) and halted in the next cycle.
- R6: While halted is 1, pop_req produces no ptr_vld. Host writes are still stored, up to the queue depth of DEPTH entries (default 8).
- R7: ctl_continue clears halted. Queue contents and err_flags stay unchanged, so the next pop returns the oldest stored pointer.
- R8: ctl_reset empties the queue and clears err_flags, err_irq and halted in the next cycle. It takes priority over every other input in that cycle.
- R9: With sts_clr_en high, each 1 in sts_clr_mask clears the matching err_flags bit. A flag that is being set in the same cycle stays set. err_irq is 1 exactly while any flag is set. Clearing flags does not clear halted.
- R10: A host write to a full queue in the same cycle as an accepted pop is stored, and no overflow is flagged.
- R11: When a halting error and ctl_continue arrive in the same cycle, halted stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host pointer write strobe |
| host_wr_ptr | input | PTR_W | Pointer written by the host |
| sts_clr_en | input | 1 | Status write strobe (write 1 to clear) |
| sts_clr_mask | input | 3 | Flags to clear: bit0 soft overflow, bit1 hard overflow, bit2 bus error |
| ctl_continue | input | 1 | Continue command: resume a halted channel |
| ctl_reset | input | 1 | Channel reset command: flush the queue and clear the flags |
| pop_req | input | 1 | Channel request for the next pointer |
| mst_err | input | 1 | Bus-master transfer error pulse |
| ptr_vld | output | 1 | Popped pointer valid (one cycle) |
| ptr_data | output | PTR_W | Popped pointer |
| err_flags | output | 3 | Sticky error flags: bit0 soft overflow, bit1 hard overflow, bit2 bus error |
| err_irq | output | 1 | Error interrupt, high while any flag is set |
| halted | output | 1 | Channel is halted |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a host write and a channel pop on a full queue. The bench fills the queue, raises host_wr_en and pop_req on the same edge, and checks three things: err_flags stays clear, and the oldest pointer appears. Draining the queue then returns the new pointer last. The second pair is a halting bus error and a continue command. The bench asserts both on one edge and expects halted to stay high. It likewise pairs a flag clear with a new bus error and expects the flag to remain set.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  localparam int ERR_OVF1 = 0;
  localparam int ERR_OVF2 = 1;
  localparam int ERR_BUS  = 2;
  localparam int NUM_ERR  = 3;
  typedef logic [NUM_ERR-1:0] err_vec_t;
endpackage

// File: rtl/dfc_ptr_fifo.sv
module dfc_ptr_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_idx, rd_idx;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] i);
    return (i == LAST) ? '0 : i + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  // storage: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (wr_en) wr_idx <= bump(wr_idx);
      if (rd_en) rd_idx <= bump(rd_idx);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R2
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty && !rd_vld));
endmodule

// File: rtl/dfc_err_ctl.sv
module dfc_err_ctl (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ovf_evt,
  input  logic                  bus_err,
  input  logic                  clr_en,
  input  dfc_pkg::err_vec_t     clr_mask,
  input  logic                  cmd_cont,
  input  logic                  cmd_rst,
  output dfc_pkg::err_vec_t     flags,
  output logic                  irq,
  output logic                  halted
);
  import dfc_pkg::*;

  err_vec_t nxt_flags;
  logic     nxt_halt, halt_evt;

  always_comb begin
    nxt_flags = flags;
    if (clr_en) nxt_flags = nxt_flags & ~clr_mask;
    if (ovf_evt) begin
      nxt_flags[ERR_OVF1] = 1'b1;
      if (flags[ERR_OVF1]) nxt_flags[ERR_OVF2] = 1'b1;
    end
    if (bus_err) nxt_flags[ERR_BUS] = 1'b1;
    halt_evt = (ovf_evt && flags[ERR_OVF1]) || bus_err;
    nxt_halt = halted;
    if (cmd_cont) nxt_halt = 1'b0;
    if (halt_evt) nxt_halt = 1'b1;
    if (cmd_rst) begin
      nxt_flags = '0;
      nxt_halt  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      irq    <= 1'b0;
      halted <= 1'b0;
    end else begin
      flags  <= nxt_flags;
      irq    <= |nxt_flags;
      halted <= nxt_halt;
    end
  end

  // R4
  hard_ovf_halt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[ERR_OVF2]) |-> halted);
  // R5
  bus_err_halt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[ERR_BUS]) |-> halted);
  // R9
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|flags));
  // R8
  cmd_rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_rst |=> (flags == '0 && !halted));
endmodule

// File: rtl/desc_fetch_chan.sv
module desc_fetch_chan #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         host_wr_en,
  input  logic [PTR_W-1:0]             host_wr_ptr,
  input  logic                         sts_clr_en,
  input  logic [dfc_pkg::NUM_ERR-1:0]  sts_clr_mask,
  input  logic                         ctl_continue,
  input  logic                         ctl_reset,
  input  logic                         pop_req,
  input  logic                         mst_err,
  output logic                         ptr_vld,
  output logic [PTR_W-1:0]             ptr_data,
  output logic [dfc_pkg::NUM_ERR-1:0]  err_flags,
  output logic                         err_irq,
  output logic                         halted
);
  logic q_full, q_empty;
  logic pop_fire, wr_acc, ovf_evt;

  assign pop_fire = pop_req && !halted && !q_empty && !ctl_reset;
  assign wr_acc   = host_wr_en && (!q_full || pop_fire) && !ctl_reset;
  assign ovf_evt  = host_wr_en && q_full && !pop_fire && !ctl_reset;

  dfc_ptr_fifo #(.DEPTH(DEPTH), .DW(PTR_W)) i_fifo (
    .clk     (clk),
    .rst     (rst),
    .flush   (ctl_reset),
    .wr_en   (wr_acc),
    .wr_data (host_wr_ptr),
    .rd_en   (pop_fire),
    .rd_data (ptr_data),
    .rd_vld  (ptr_vld),
    .full    (q_full),
    .empty   (q_empty)
  );

  dfc_err_ctl i_err (
    .clk      (clk),
    .rst      (rst),
    .ovf_evt  (ovf_evt),
    .bus_err  (mst_err),
    .clr_en   (sts_clr_en),
    .clr_mask (sts_clr_mask),
    .cmd_cont (ctl_continue),
    .cmd_rst  (ctl_reset),
    .flags    (err_flags),
    .irq      (err_irq),
    .halted   (halted)
  );

  // R6
  halted_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> !ptr_vld);
  // R3
  soft_ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> err_flags[dfc_pkg::ERR_OVF1]);
endmodule

// File: tb/test_desc_fetch_chan.sv
module test_desc_fetch_chan;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam logic [31:0] VEC [DEPTH] = '{
    32'h1000_0010, 32'h2000_0020, 32'h3000_0030, 32'h4000_0040,
    32'h5000_0050, 32'h6000_0060, 32'h7000_0070, 32'h8000_0080};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr_en = 0, sts_clr_en = 0, ctl_continue = 0, ctl_reset = 0;
  logic pop_req = 0, mst_err = 0;
  logic [31:0] host_wr_ptr = '0;
  logic [2:0]  sts_clr_mask = '0;
  logic ptr_vld, err_irq, halted;
  logic [31:0] ptr_data;
  logic [2:0]  err_flags;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_fetch_chan #(.DEPTH(DEPTH), .PTR_W(32)) i_desc_fetch_chan (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_ptr(host_wr_ptr),
    .sts_clr_en(sts_clr_en), .sts_clr_mask(sts_clr_mask),
    .ctl_continue(ctl_continue), .ctl_reset(ctl_reset), .pop_req(pop_req),
    .mst_err(mst_err), .ptr_vld(ptr_vld), .ptr_data(ptr_data),
    .err_flags(err_flags), .err_irq(err_irq), .halted(halted));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock edge; outputs sampled a quarter period after it
  task automatic cyc();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic wr(input logic [31:0] p);
    host_wr_en = 1; host_wr_ptr = p; cyc(); host_wr_en = 0;
  endtask

  task automatic pop_expect(input string tag, input bit vld, input logic [31:0] p);
    pop_req = 1; cyc(); pop_req = 0;
    chk({tag, " vld"}, {31'b0, ptr_vld}, {31'b0, vld});
    if (vld) chk({tag, " data"}, ptr_data, p);
  endtask

  task automatic clr(input logic [2:0] m);
    sts_clr_en = 1; sts_clr_mask = m; cyc(); sts_clr_en = 0; sts_clr_mask = 0;
  endtask

  task automatic creset();
    ctl_reset = 1; cyc(); ctl_reset = 0;
  endtask

  task automatic cont();
    ctl_continue = 1; cyc(); ctl_continue = 0;
  endtask

  task automatic fill(input logic [31:0] xr);
    for (int i = 0; i < DEPTH; i++) wr(VEC[i] ^ xr);
  endtask

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk("R1 flags", {29'b0, err_flags}, 32'h0);
    chk("R1 irq", {31'b0, err_irq}, 32'h0);
    chk("R1 halted", {31'b0, halted}, 32'h0);
    chk("R1 vld", {31'b0, ptr_vld}, 32'h0);

    // R2 pop on empty
    pop_expect("R2 empty", 0, 0);

    // vector table walk, then soft overflow
    fill(32'h0);
    wr(32'hDEAD_0001);
    chk("R3 flags", {29'b0, err_flags}, 32'h1);
    chk("R3 irq", {31'b0, err_irq}, 32'h1);
    chk("R3 halted", {31'b0, halted}, 32'h0);
    for (int i = 0; i < DEPTH; i++) pop_expect("R2 order", 1, VEC[i]);
    pop_expect("R3 dropped", 0, 0);
    clr(3'b001);
    chk("R9 clear flags", {29'b0, err_flags}, 32'h0);
    chk("R9 clear irq", {31'b0, err_irq}, 32'h0);

    // R4 hard overflow
    fill(32'h0000_FFFF);
    wr(32'hDEAD_0002);
    chk("R4 first", {29'b0, err_flags}, 32'h1);
    wr(32'hDEAD_0003);
    chk("R4 flags", {29'b0, err_flags}, 32'h3);
    chk("R4 halted", {31'b0, halted}, 32'h1);
    pop_expect("R6 halted pop", 0, 0);
    clr(3'b011);
    chk("R9 clr flags", {29'b0, err_flags}, 32'h0);
    chk("R9 clr keeps halt", {31'b0, halted}, 32'h1);
    cont();
    chk("R7 resumed", {31'b0, halted}, 32'h0);
    pop_expect("R7 kept", 1, VEC[0] ^ 32'h0000_FFFF);
    creset();
    chk("R8 halted", {31'b0, halted}, 32'h0);
    pop_expect("R8 flushed", 0, 0);

    // R5 bus error, R6 writes while halted
    wr(32'hA0);
    wr(32'hA1);
    mst_err = 1; cyc(); mst_err = 0;
    chk("R5 flags", {29'b0, err_flags}, 32'h4);
    chk("R5 halted", {31'b0, halted}, 32'h1);
    pop_expect("R6 no pop", 0, 0);
    wr(32'hA2); wr(32'hA3); wr(32'hA4);
    cont();
    chk("R7 flags kept", {29'b0, err_flags}, 32'h4);
    for (int i = 0; i < 5; i++) pop_expect("R6 stored", 1, 32'hA0 + i);
    creset();
    chk("R8 flags", {29'b0, err_flags}, 32'h0);
    chk("R8 irq", {31'b0, err_irq}, 32'h0);

    // R10 write and pop in one cycle on a full queue
    fill(32'h0F00_0000);
    host_wr_en = 1; host_wr_ptr = 32'hBEEF_0000; pop_req = 1;
    cyc();
    host_wr_en = 0; pop_req = 0;
    chk("R10 vld", {31'b0, ptr_vld}, 32'h1);
    chk("R10 data", ptr_data, VEC[0] ^ 32'h0F00_0000);
    chk("R10 flags", {29'b0, err_flags}, 32'h0);
    for (int i = 1; i < DEPTH; i++) pop_expect("R10 drain", 1, VEC[i] ^ 32'h0F00_0000);
    pop_expect("R10 new", 1, 32'hBEEF_0000);

    // R11 halting error with continue in the same cycle
    mst_err = 1; cyc(); mst_err = 0;
    mst_err = 1; ctl_continue = 1; cyc(); mst_err = 0; ctl_continue = 0;
    chk("R11 halted", {31'b0, halted}, 32'h1);
    // R9 clear and set in the same cycle
    mst_err = 1; sts_clr_en = 1; sts_clr_mask = 3'b100; cyc();
    mst_err = 0; sts_clr_en = 0; sts_clr_mask = 0;
    chk("R9 set wins", {29'b0, err_flags}, 32'h4);
    creset();

    // R9 irq held while any flag remains
    mst_err = 1; cyc(); mst_err = 0;
    cont();
    fill(32'h0);
    wr(32'hDEAD_0004);
    chk("R9 two flags", {29'b0, err_flags}, 32'h5);
    clr(3'b001);
    chk("R9 partial flags", {29'b0, err_flags}, 32'h4);
    chk("R9 irq held", {31'b0, err_irq}, 32'h1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule